// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel words. A one-cycle enable pulse marks every tick of a clock that runs at sixteen times the bit rate. The receiver finds a start bit by its falling edge and confirms it at mid-bit. It then samples each data bit, the optional parity bit and the first stop bit once, at the centre of the bit, with the least significant data bit first. The finished word moves into a holding register. The shift path can then take in the next frame while the host has not yet read the previous word.

Each held word carries four status flags: parity error, framing error, break and overrun. A read strobe takes the word and clears all four flags together. A loopback select makes the receiver listen to the local transmit line in place of the external input. Word length, parity mode and loopback are static controls. They may change only while the line is idle.

Top module: `async_rx`

## Requirements
- R1: After reset, `rvalid`, `perr`, `ferr`, `brk` and `oerr` are 0 and `rdata` is 0x00.
- R2: A high-to-low change of the line between two ticks opens a frame only if the line is still low on the 8th tick counted from the tick that saw it low. If the line is high on that tick, no word is produced.
- R3: `word_len` sets 5 + `word_len` data bits (codes 0 to 3 give 5 to 8 bits). Each bit is sampled once, 16 ticks after the previous sample point, and the first bit received is bit 0. Unused upper bits of `rdata` read 0.
- R4: With `par_en`=1 a parity bit follows the data bits. If `par_odd`=0 the data bits plus the parity bit must hold an even number of ones, and if `par_odd`=1 an odd number. A mismatch sets `perr` for that word. With `par_en`=0 no parity bit is expected and `perr` stays 0.
- R5: `ferr` is set for a word whose first stop bit is sampled low.
- R6: `brk` is set for a word whose data bits, parity bit (when enabled) and stop bit are all low.
- R7: `rvalid` rises on the clock after the stop-bit sample tick, with `rdata` and the flags of that word. It stays set until a cycle with `rd_take`=1. That read clears `rvalid` and all four flags and leaves `rdata` unchanged.
- R8: If a word completes while `rvalid`=1 and `rd_take`=0, then `oerr` is set and the new word with its flags replaces the old one.
- R9: If `rd_take`=1 in the same cycle that a word completes, the old word counts as read, the new word becomes valid and `oerr` stays 0.
- R10: With `loop_en`=1 the receiver takes its input from `tx_serial` and ignores `rx_serial`. With `loop_en`=0 it ignores `tx_serial`.
- R11: After a frame the line must be seen high on a tick before a new start can be detected. A line held low after a break yields no further words.
- R12: `rd_take` while `rvalid`=0 changes neither `rvalid` nor `rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_serial | input | 1 | External serial input, idle high |
| tx_serial | input | 1 | Local transmit line, used in loopback |
| loop_en | input | 1 | Selects tx_serial as the receive source |
| word_len | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_take | input | 1 | Host read strobe for the holding register |
| rdata | output | 8 | Held data word, right aligned |
| rvalid | output | 1 | Holding register holds an unread word |
| perr | output | 1 | Parity error for the held word |
| ferr | output | 1 | Framing error for the held word |
| brk | output | 1 | Break detected for the held word |
| oerr | output | 1 | Held word overwrote an unread one |

## Verification
Two functions can fall in the same clock: loading a completed word into the holding register and the host read that empties it. The bench places a single-cycle `rd_take` exactly on the stop-bit sample tick of a second frame. The cycle is known in advance because the tick period is fixed and the sample falls on the 8th tick of the stop bit. The result must be the new word valid with `oerr` clear. The opposite case is also run: the same frame pair with no read gives `oerr` set. A behavioural model that counts ticks since the falling edge is compared with every output on every clock.

// File: rtl/async_rx.sv
module async_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_serial,
  input  logic       tx_serial,
  input  logic       loop_en,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rd_take,
  output logic [7:0] rdata,
  output logic       rvalid,
  output logic       perr,
  output logic       ferr,
  output logic       brk,
  output logic       oerr
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 2);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic          pbit;
  logic          line_q;

  wire       line     = loop_en ? tx_serial : rx_serial;
  wire       at_mid   = tick && cnt == LAST;
  wire [2:0] last_idx = 3'd4 + {1'b0, word_len};
  wire       done     = st == S_STOP && at_mid;
  wire [7:0] word     = sh >> (2'd3 - word_len);
  wire       par_bad  = par_en && (^word ^ pbit ^ par_odd);
  wire       all_low  = word == 8'd0 && (!par_en || !pbit) && !line;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      line_q <= 1'b1;
    end else if (tick) begin
      line_q <= line;
      case (st)
        S_IDLE:
          if (line_q && !line) begin
            st  <= S_START;
            cnt <= '0;
          end
        S_START:
          if (cnt == MID) begin
            st  <= line ? S_IDLE : S_DATA;
            cnt <= '0;
            idx <= '0;
          end else cnt <= cnt + CW'(1);
        default:
          if (cnt == LAST) begin
            cnt <= '0;
            case (st)
              S_DATA: begin
                sh  <= {line, sh[7:1]};
                idx <= idx + 3'd1;
                if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
              end
              S_PAR: begin
                pbit <= line;
                st   <= S_STOP;
              end
              default: st <= S_IDLE;
            endcase
          end else cnt <= cnt + CW'(1);
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
      brk    <= 1'b0;
      oerr   <= 1'b0;
    end else if (done) begin
      rdata  <= word;
      rvalid <= 1'b1;
      perr   <= par_bad;
      ferr   <= !line;
      brk    <= all_low;
      oerr   <= rvalid && !rd_take;
    end else if (rd_take && rvalid) begin
      rvalid <= 1'b0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
      brk    <= 1'b0;
      oerr   <= 1'b0;
    end

  AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_START && tick && cnt == MID && line |=> st == S_IDLE); // R2
  AST_LAST_BIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_DATA && at_mid && idx == last_idx |=> st == S_PAR || st == S_STOP); // R3
  AST_BRK_WITH_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> ferr); // R6
  AST_FLAGS_NEED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (perr || ferr || brk || oerr) |-> rvalid); // R7
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && rd_take && !done |=> !rvalid && $stable(rdata)); // R7
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done && rvalid && !rd_take |=> oerr && rvalid); // R8
  AST_COINCIDENT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done && rd_take |=> rvalid && !oerr); // R9
  AST_NEEDS_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && !line_q |=> st != S_START); // R11
  AST_IDLE_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid && !done |=> !rvalid && $stable(rdata)); // R12
endmodule

// File: tb/async_rx_tb.sv
module async_rx_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic rx_serial = 1'b1, tx_serial = 1'b0, loop_en = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic par_en = 1'b0, par_odd = 1'b0, rd_take = 1'b0;
  logic [7:0] rdata;
  logic rvalid, perr, ferr, brk, oerr;
  logic [1:0] tc = 2'd0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  async_rx u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .rx_serial(rx_serial),
    .tx_serial(tx_serial), .loop_en(loop_en), .word_len(word_len), .par_en(par_en),
    .par_odd(par_odd), .rd_take(rd_take), .rdata(rdata), .rvalid(rvalid),
    .perr(perr), .ferr(ferr), .brk(brk), .oerr(oerr));

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk)
    if (!rst_n) begin tc <= 2'd0; tick <= 1'b0; end
    else begin tc <= tc + 2'd1; tick <= (tc == 2'd3); end

  // behavioural reference: counts ticks since the falling edge
  logic e_valid, e_perr, e_ferr, e_brk, e_oerr;
  logic [7:0] e_data, wd;
  bit m_busy, m_prev, fin, allz;
  int m_k, nb, need, ones;
  bit q[$];
  logic ml;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e_data = 0; e_perr = 0; e_ferr = 0; e_brk = 0; e_oerr = 0;
      m_busy = 0; m_prev = 1; m_k = 0; q.delete();
    end else begin
      ml = loop_en ? tx_serial : rx_serial;
      fin = 0;
      nb = 5 + int'(word_len);
      need = nb + (par_en ? 1 : 0) + 1;
      if (tick) begin
        if (!m_busy) begin
          if (m_prev && !ml) begin m_busy = 1; m_k = 1; q.delete(); end
        end else begin
          m_k++;
          if (m_k % 16 == 8) begin
            if (m_k == 8) begin
              if (ml) m_busy = 0;
            end else begin
              q.push_back(ml);
              if (q.size() == need) begin fin = 1; m_busy = 0; end
            end
          end
        end
        m_prev = ml;
      end
      if (fin) begin
        wd = 0; ones = 0; allz = 1;
        for (int i = 0; i < need; i++) if (q[i]) allz = 0;
        for (int i = 0; i < nb; i++) begin wd[i] = q[i]; ones += int'(q[i]); end
        e_oerr = e_valid && !rd_take;
        e_valid = 1; e_data = wd; e_ferr = !q[need-1]; e_brk = allz;
        e_perr = par_en && (((ones + int'(q[nb])) % 2) != (par_odd ? 1 : 0));
      end else if (rd_take && e_valid) begin
        e_valid = 0; e_perr = 0; e_ferr = 0; e_brk = 0; e_oerr = 0;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      n_chk++;
      if ({rvalid, rdata, perr, ferr, brk, oerr} !== {e_valid, e_data, e_perr, e_ferr, e_brk, e_oerr}) begin
        n_fail++;
        $display("FAIL %s model: actual v=%b d=%h p%b f%b b%b o%b expected v=%b d=%h p%b f%b b%b o%b",
          cur_req, rvalid, rdata, perr, ferr, brk, oerr, e_valid, e_data, e_perr, e_ferr, e_brk, e_oerr);
      end
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic drv(input logic b);
    if (loop_en) begin tx_serial = b; rx_serial = ~b; end
    else begin rx_serial = b; tx_serial = ~b; end
  endtask

  task automatic do_read();
    rd_take = 1'b1;
    @(negedge clk);
    rd_take = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int bits, input bit pe, input bit po,
                            input bit flip, input bit stopv, input bit lp, input bit rd_at_stop);
    bit p;
    loop_en = lp; word_len = 2'(bits - 5); par_en = pe; par_odd = po;
    drv(1'b1); wait_ticks(4);
    drv(1'b0); wait_ticks(16);
    p = po;
    for (int i = 0; i < bits; i++) begin drv(d[i]); p ^= d[i]; wait_ticks(16); end
    if (pe) begin drv(p ^ flip); wait_ticks(16); end
    drv(stopv);
    if (rd_at_stop) begin
      wait_ticks(7);
      repeat (3) @(negedge clk);
      rd_take = 1'b1;
      @(negedge clk);
      rd_take = 1'b0;
      wait_ticks(8);
    end else wait_ticks(16);
  endtask

  task automatic idle(input int n);
    drv(1'b1); wait_ticks(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rvalid", {7'd0, rvalid}, 8'd0);
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 flags", {4'd0, perr, ferr, brk, oerr}, 8'd0);
    rst_n = 1'b1;
    idle(8);

    cur_req = "R3";
    send_frame(8'hA5, 8, 0, 0, 0, 1, 0, 0); idle(4);
    chk("R3 8 bits", rdata, 8'hA5);
    chk("R7 valid", {7'd0, rvalid}, 8'd1);
    do_read();
    chk("R7 cleared", {7'd0, rvalid}, 8'd0);
    chk("R7 data kept", rdata, 8'hA5);
    for (int b = 5; b < 8; b++) begin
      send_frame(8'hDB, b, 0, 0, 0, 1, 0, 0); idle(4);
      chk("R3 short word", rdata, 8'hDB & 8'((1 << b) - 1));
      do_read();
    end

    cur_req = "R4";
    send_frame(8'h3C, 8, 1, 0, 0, 1, 0, 0); idle(4);
    chk("R4 even ok", {7'd0, perr}, 8'd0); do_read();
    send_frame(8'h3C, 8, 1, 0, 1, 1, 0, 0); idle(4);
    chk("R4 even bad", {7'd0, perr}, 8'd1); do_read();
    chk("R7 perr cleared", {7'd0, perr}, 8'd0);
    send_frame(8'h07, 7, 1, 1, 0, 1, 0, 0); idle(4);
    chk("R4 odd ok", {7'd0, perr}, 8'd0); do_read();
    send_frame(8'h07, 7, 1, 1, 1, 1, 0, 0); idle(4);
    chk("R4 odd bad", {7'd0, perr}, 8'd1); do_read();

    cur_req = "R5";
    send_frame(8'h55, 8, 0, 0, 0, 0, 0, 0); idle(4);
    chk("R5 ferr", {6'd0, ferr, brk}, 8'b10); do_read();

    cur_req = "R6";
    send_frame(8'h00, 8, 1, 0, 0, 0, 0, 0);
    chk("R6 brk", {6'd0, ferr, brk}, 8'b11); do_read();
    cur_req = "R11";
    wait_ticks(48);
    chk("R11 no restart", {7'd0, rvalid}, 8'd0);
    idle(8);

    cur_req = "R2";
    drv(1'b0); wait_ticks(4); drv(1'b1); wait_ticks(40);
    chk("R2 glitch", {7'd0, rvalid}, 8'd0);

    cur_req = "R8";
    send_frame(8'h11, 8, 0, 0, 0, 1, 0, 0);
    send_frame(8'h22, 8, 0, 0, 0, 1, 0, 0); idle(4);
    chk("R8 new word", rdata, 8'h22);
    chk("R8 oerr", {7'd0, oerr}, 8'd1);
    do_read();
    chk("R7 oerr cleared", {7'd0, oerr}, 8'd0);

    cur_req = "R9";
    send_frame(8'h33, 8, 0, 0, 0, 1, 0, 0);
    send_frame(8'h44, 8, 0, 0, 0, 1, 0, 1); idle(4);
    chk("R9 data", rdata, 8'h44);
    chk("R9 valid no oerr", {6'd0, rvalid, oerr}, 8'b10);

    cur_req = "R12";
    do_read(); do_read();
    chk("R12 still empty", {7'd0, rvalid}, 8'd0);
    chk("R12 data kept", rdata, 8'h44);

    cur_req = "R10";
    send_frame(8'h96, 8, 0, 0, 0, 1, 1, 0); idle(4);
    chk("R10 loopback", rdata, 8'h96);
    do_read();
    loop_en = 1'b0; idle(8);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule